// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents them to a processor through a byte-wide bus. The bus has a command port and a data port, chosen by `a0`, and is qualified by a chip select and read and write strobes. The controller keeps three 8-bit registers: pending requests, requests in service and a mask. It raises `int_out` when a request needs attention. When it sees a one-cycle `ack` pulse, it returns an 8-bit vector on `vec_out` together with `vec_valid`.

Software must program the block before it does anything. A command-port write with bit 4 set opens the setup sequence, and three data-port writes complete it. After that the processor changes masks, retires serviced levels and chooses which register the command port reads back.

Configuration is held by a five-state machine:
- `ST_UNINIT` is the state after reset.
- `ST_ICW2`, `ST_ICW3` and `ST_ICW4` take the three setup words.
- `ST_READY` is normal operation.

The transitions are:
- *setup start*: any state goes to `ST_ICW2` on a command write with bit 4 set.
- *base taken*: `ST_ICW2` goes to `ST_ICW3`.
- *cascade taken*: `ST_ICW3` goes to `ST_ICW4`.
- *mode taken*: `ST_ICW4` goes to `ST_READY`.
- Each of the last three is taken on a data-port write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request and in-service registers read 0x00, the mask reads 0xFF and command-port reads return requests. `int_out` stays low and `ack` produces no `vec_valid` until a setup sequence has completed.
- R2: A command write with bit 4 set (0x11 for edge, 0x19 with bit 3 set for level) starts setup and clears requests, in-service bits and the read select. The next three data writes are the base, cascade and mode words, in that order. Normal operation follows the mode word, and the mask is left unchanged by setup.
- R3: The vector for input n is the base word with bits 2:0 replaced by n, so a base of 0x30 gives 0x30–0x37.
- R4: The cascade word is kept unchanged and driven on `cascade_cfg`.
- R5: A data-port write in normal operation loads the mask, where a 1 blocks that input. Data-port reads return the mask, and a mask write leaves in-service bits untouched.
- R6: Priority is fixed with input 0 highest. `int_out` is high only when an unmasked pending input has a lower index than every set in-service bit.
- R7: `ack` yields `vec_valid` with the vector one cycle later and sets the winner's in-service bit, unless auto-EOI (mode word bit 1) is set. In edge mode it also clears the winner's request bit.
- R8: A command write of 0x60+n clears in-service bit n and no other bit.
- R9: A command write of 0x0A selects requests and 0x0B selects in-service bits for later command-port reads. The selection holds until it is changed.
- R10: An `ack` with no eligible request returns the level-7 vector and sets no in-service bit, even when input 7 is masked.
- R11: In edge mode a request bit is set by a rising input and dropped when the input falls. An input held high after acknowledge does not request again. In level mode the request bit follows the input and `ack` does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; one write per clock it is low |
| a0 | input | 1 | Port select: 0 command, 1 data |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| irq_in | input | 8 | Interrupt request inputs |
| ack | input | 1 | Acknowledge pulse, one cycle |
| int_out | output | 1 | Interrupt to the processor |
| vec_out | output | 8 | Vector returned after acknowledge |
| vec_valid | output | 1 | Vector valid, one cycle |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
A corrupted in-service register shows at the ports within one cycle. Either `int_out` stays low while a higher-priority request waits, or it goes high for a level that should be blocked. The next 0x0B read-back exposes it directly. A wrong request register shows on the next `ack` as a wrong vector or a false level-7 answer, one cycle after the pulse. A setup machine stuck in the wrong state keeps `int_out` low, or sends a mask write to a setup register, and the following vector or mask read shows this.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_ICW2,
        ST_ICW3,
        ST_ICW4,
        ST_READY
    } cfg_state_t;

    // command-byte field positions that decide how a command write is read
    localparam int SETUP_BIT    = 4;
    localparam int LEVEL_BIT    = 3;
    localparam int SELCMD_BIT   = 3;
    localparam int SEL_EN_BIT   = 1;
    localparam int SEL_ISR_BIT  = 0;
    localparam int AEOI_BIT     = 1;
    localparam logic [2:0] SEOI_OP = 3'b011;

endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
    import prio_irq_pkg::*;
#(
    parameter int NUM_IN = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NUM_IN),
    localparam int HI_W  = DATA_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] din,
    output logic              ready,
    output logic              level_mode,
    output logic              auto_eoi,
    output logic [HI_W-1:0]   base_hi,
    output logic [DATA_W-1:0] cascade_cfg,
    output logic [NUM_IN-1:0] imr,
    output logic              sel_isr,
    output logic              setup_start,
    output logic              eoi_valid,
    output logic [IDX_W-1:0]  eoi_idx
);

    cfg_state_t state_q, state_d;
    logic       sel_cmd;

    // command decode
    always_comb begin
        setup_start = wr_cmd && din[SETUP_BIT];
        sel_cmd     = wr_cmd && !din[SETUP_BIT] && din[SELCMD_BIT]
                      && din[SEL_EN_BIT] && (state_q == ST_READY);
        eoi_valid   = wr_cmd && !din[SETUP_BIT] && !din[SELCMD_BIT]
                      && (din[DATA_W-1:DATA_W-3] == SEOI_OP)
                      && (state_q == ST_READY);
        eoi_idx     = din[IDX_W-1:0];
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (setup_start) begin
            state_d = ST_ICW2;
        end else begin
            unique case (state_q)
                ST_UNINIT: state_d = ST_UNINIT;
                ST_ICW2:   if (wr_data) state_d = ST_ICW3;
                ST_ICW3:   if (wr_data) state_d = ST_ICW4;
                ST_ICW4:   if (wr_data) state_d = ST_READY;
                ST_READY:  state_d = ST_READY;
                default:   state_d = ST_UNINIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        ready = (state_q == ST_READY);
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_mode  <= 1'b0;
            auto_eoi    <= 1'b0;
            base_hi     <= '0;
            cascade_cfg <= '0;
            imr         <= '1;
            sel_isr     <= 1'b0;
        end else begin
            if (setup_start) begin
                level_mode <= din[LEVEL_BIT];
                sel_isr    <= 1'b0;
            end else if (sel_cmd) begin
                sel_isr <= din[SEL_ISR_BIT];
            end
            if (wr_data) begin
                unique case (state_q)
                    ST_ICW2: base_hi     <= din[DATA_W-1:IDX_W];
                    ST_ICW3: cascade_cfg <= din;
                    ST_ICW4: auto_eoi    <= din[AEOI_BIT];
                    default: imr         <= din[NUM_IN-1:0];
                endcase
            end
        end
    end

endmodule

// File: rtl/prio_irq_req.sv
module prio_irq_req #(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] req_in,
    input  logic              level_mode,
    input  logic              flush,
    input  logic [NUM_IN-1:0] ack_clr,
    output logic [NUM_IN-1:0] irr
);

    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        logic prev_q;
        logic irr_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b1;
                irr_q  <= 1'b0;
            end else begin
                prev_q <= req_in[g];
                if (flush)
                    irr_q <= 1'b0;
                else if (level_mode)
                    irr_q <= req_in[g];
                else
                    irr_q <= (irr_q && req_in[g] && !ack_clr[g])
                             || (req_in[g] && !prev_q);
            end
        end
        assign irr[g] = irr_q;
    end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
    parameter int NUM_IN = 8,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0] irr,
    input  logic [NUM_IN-1:0] imr,
    input  logic [NUM_IN-1:0] isr,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx
);

    logic [NUM_IN-1:0] elig;

    always_comb begin
        logic busy;
        busy = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            busy    = busy | isr[i];
            elig[i] = irr[i] & ~imr[i] & ~busy;
        end
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_IN = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NUM_IN),
    localparam int HI_W  = DATA_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              ack,
    output logic              int_out,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_valid,
    output logic [DATA_W-1:0] cascade_cfg
);

    logic              wr_cmd, wr_data;
    logic              ready, level_mode, auto_eoi, sel_isr;
    logic              setup_start, eoi_valid;
    logic [IDX_W-1:0]  eoi_idx, win_idx;
    logic [HI_W-1:0]   base_hi;
    logic [NUM_IN-1:0] imr, irr, isr, ack_clr, isr_set, isr_clr;
    logic              win_valid, ack_take;

    assign wr_cmd  = !cs_n && !wr_n && !a0;
    assign wr_data = !cs_n && !wr_n &&  a0;

    prio_irq_cfg #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .din(din), .ready(ready), .level_mode(level_mode),
        .auto_eoi(auto_eoi), .base_hi(base_hi), .cascade_cfg(cascade_cfg),
        .imr(imr), .sel_isr(sel_isr), .setup_start(setup_start),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx)
    );

    prio_irq_req #(.NUM_IN(NUM_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .req_in(irq_in), .level_mode(level_mode),
        .flush(setup_start), .ack_clr(ack_clr), .irr(irr)
    );

    prio_irq_arb #(.NUM_IN(NUM_IN)) u_arb (
        .irr(irr), .imr(imr), .isr(isr),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    always_comb begin
        ack_take = ack && ready;
        ack_clr  = (ack_take && win_valid) ? (NUM_IN'(1) << win_idx) : '0;
        isr_set  = auto_eoi ? '0 : ack_clr;
        isr_clr  = eoi_valid ? (NUM_IN'(1) << eoi_idx) : '0;
        int_out  = ready && win_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr       <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            if (setup_start) isr <= '0;
            else             isr <= (isr & ~isr_clr) | isr_set;
            vec_valid <= ack_take;
            if (ack_take)
                vec_out <= {base_hi, win_valid ? win_idx : IDX_W'(NUM_IN - 1)};
        end
    end

    always_comb begin
        dout = '0;
        if (!cs_n && !rd_n)
            dout = a0 ? DATA_W'(imr) : (sel_isr ? DATA_W'(isr) : DATA_W'(irr));
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int NUM_IN = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              ready,
    input logic              auto_eoi,
    input logic              int_out,
    input logic              vec_valid,
    input logic [DATA_W-1:0] vec_out,
    input logic [NUM_IN-1:0] irr,
    input logic [NUM_IN-1:0] imr,
    input logic [NUM_IN-1:0] isr
);

    // R7
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && ready |=> vec_valid);

    // R1
    idle_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    // R7
    aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && ready && auto_eoi |=> (isr & ~$past(isr)) == '0);

    // R10
    spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && ready && !int_out |=>
            (vec_out[IDX_W-1:0] == IDX_W'(NUM_IN - 1)) && ((isr & ~$past(isr)) == '0));

    // R6
    int_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (irr & ~imr) != '0);

    // R7
    isr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .ready(ready), .auto_eoi(auto_eoi),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
    .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0;
    logic       int_out, vec_valid;
    logic [7:0] vec_out, cascade_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rv;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .dout(dout), .irq_in(irq_in), .ack(ack),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid),
        .cascade_cfg(cascade_cfg)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = port; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic port, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = port;
        #1 d = dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    // driver: push the expected vector, then pulse acknowledge
    task automatic do_ack(input logic [7:0] exp);
        @(negedge clk);
        exp_q.push_back(exp);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic setup(input logic [7:0] w1, input logic [7:0] base,
                         input logic [7:0] casc, input logic [7:0] mode);
        bus_wr(1'b0, w1);
        bus_wr(1'b1, base);
        bus_wr(1'b1, casc);
        bus_wr(1'b1, mode);
    endtask

    // monitor: compare every produced vector with the scoreboard (R3, R7)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && vec_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected vector", vec_out, 8'hxx);
                end else begin
                    check("R3 R7 vector", vec_out, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_rd(1'b1, rv); check("R1 mask", rv, 8'hFF);
        bus_rd(1'b0, rv); check("R1 irr", rv, 8'h00);
        check("R1 int", {7'd0, int_out}, 8'h00);
        set_irq(8'h01);
        check("R1 int before setup", {7'd0, int_out}, 8'h00);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R1 ack ignored", {7'd0, vec_valid}, 8'h00);
        set_irq(8'h00);

        // R2 R4 setup, edge mode, base 0x20
        setup(8'h11, 8'h20, 8'h04, 8'h01);
        check("R4 cascade", cascade_cfg, 8'h04);
        bus_rd(1'b1, rv); check("R2 mask kept", rv, 8'hFF);
        bus_wr(1'b1, 8'h00);
        bus_rd(1'b1, rv); check("R5 mask write", rv, 8'h00);

        // R6 R7 R11 single request
        set_irq(8'h08);
        check("R6 int raised", {7'd0, int_out}, 8'h01);
        bus_rd(1'b0, rv); check("R11 irr edge", rv, 8'h08);
        do_ack(8'h23);
        bus_wr(1'b0, 8'h0B);
        bus_rd(1'b0, rv); check("R9 R7 isr", rv, 8'h08);
        bus_rd(1'b0, rv); check("R9 select sticky", rv, 8'h08);
        bus_wr(1'b0, 8'h0A);
        bus_rd(1'b0, rv); check("R11 irr cleared while held", rv, 8'h00);
        check("R11 no re-request", {7'd0, int_out}, 8'h00);

        // R6 nesting and R8 specific EOI
        set_irq(8'h2A);
        check("R6 higher preempts", {7'd0, int_out}, 8'h01);
        do_ack(8'h21);
        check("R6 lower blocked", {7'd0, int_out}, 8'h00);
        bus_wr(1'b0, 8'h61);
        bus_wr(1'b0, 8'h0B);
        bus_rd(1'b0, rv); check("R8 eoi one bit", rv, 8'h08);
        check("R6 still blocked", {7'd0, int_out}, 8'h00);
        bus_wr(1'b0, 8'h63);
        bus_rd(1'b0, rv); check("R8 eoi clear", rv, 8'h00);
        check("R6 released", {7'd0, int_out}, 8'h01);
        do_ack(8'h25);
        bus_rd(1'b0, rv); check("R7 isr set", rv, 8'h20);
        bus_wr(1'b0, 8'h65);
        bus_wr(1'b0, 8'h0A);

        // R5 masking
        set_irq(8'h00);
        bus_wr(1'b1, 8'h04);
        set_irq(8'h04);
        check("R5 masked", {7'd0, int_out}, 8'h00);
        bus_rd(1'b0, rv); check("R5 irr still pending", rv, 8'h04);
        bus_wr(1'b1, 8'h00);
        check("R5 unmasked", {7'd0, int_out}, 8'h01);
        do_ack(8'h22);
        bus_wr(1'b1, 8'hFF);
        bus_wr(1'b0, 8'h0B);
        bus_rd(1'b0, rv); check("R5 isr untouched", rv, 8'h04);
        bus_wr(1'b0, 8'h0A);
        bus_wr(1'b1, 8'h00);
        bus_wr(1'b0, 8'h62);

        // R10 spurious level 7
        set_irq(8'h44);
        check("R10 pending", {7'd0, int_out}, 8'h01);
        set_irq(8'h04);
        check("R11 dropped request", {7'd0, int_out}, 8'h00);
        bus_wr(1'b1, 8'h80);
        do_ack(8'h27);
        bus_wr(1'b0, 8'h0B);
        bus_rd(1'b0, rv); check("R10 no isr", rv, 8'h00);

        // R2 re-setup in level mode with auto-EOI, base 0x30
        setup(8'h19, 8'h30, 8'h02, 8'h03);
        check("R4 cascade new", cascade_cfg, 8'h02);
        bus_rd(1'b0, rv); check("R2 R9 select reset", rv, 8'h04);
        bus_rd(1'b1, rv); check("R2 mask kept", rv, 8'h80);
        check("R11 level int", {7'd0, int_out}, 8'h01);
        do_ack(8'h32);
        bus_wr(1'b0, 8'h0B);
        bus_rd(1'b0, rv); check("R7 auto-eoi", rv, 8'h00);
        check("R11 level persists", {7'd0, int_out}, 8'h01);
        do_ack(8'h32);
        set_irq(8'h00);
        check("R11 level drop", {7'd0, int_out}, 8'h00);

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule